// File: doc/BRIEF.md
# ADC Sample/Convert Sequencer

This block is the digital sequencer in front of a successive-approximation converter. It decides when the sample-hold starts acquiring, when acquisition ends and when a conversion is launched. It then waits for the converter's completion pulse and reports the result status. Acquisition can begin on a software request, or restart by itself after every conversion.

Acquisition can be closed by one of five sources, chosen by a 3-bit select field:
- a software clear strobe;
- a rising edge on an external pin;
- a timer compare event;
- a PWM interval event;
- an internal timer that counts converter clock ticks up to a programmed window length.

Asynchronous event inputs pass through a two-stage synchronizer and a rising-edge detector.

The block also reacts to low-power states of the surrounding device. A conversion that cannot keep running is dropped and never resumed. If a conversion finishes during a low-power state with the completion interrupt disabled, the block switches itself off while the enable input stays high.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted, and after it, `samp_hold`, `conv_start`, `busy`, `done`, `irq` and `conv_abort` are 0. Reset during a conversion drops it and clears `done`.
- R2: In the holding state, with the module active, a high `sw_samp_set` starts acquisition. `samp_hold` reads 1 after the next rising edge. With `auto_start`=1, acquisition begins without a request, and again right after each completed conversion.
- R3: With `trig_sel`=000, a one-cycle `sw_samp_clr` during acquisition ends it at the next edge. `samp_hold` goes to 0 and, in the same cycle, `conv_start` is 1 for exactly one cycle, `busy` is 1 and `done` is 0.
- R4: With `trig_sel`=001 (`ext_pin`), 010 (`tmr_match`) or 011 (`pwm_evt`), a rising level on the selected input during acquisition ends it. `samp_hold` falls and `conv_start` rises after the third rising clock edge following the input's rise. The two unselected event inputs have no effect.
- R5: With `trig_sel`=111, acquisition lasts `samp_time` (0 to 31) `tad_tick` periods and ends at the edge that follows. With a tick every cycle, `samp_hold` is high for `samp_time`+1 cycles.
- R6: With `trig_sel`=100, 101 or 110, no input ends acquisition.
- R7: An event-input edge that occurs while the block is not acquiring is discarded. It does not end a later acquisition.
- R8: A `conv_done` pulse during a conversion completes it at that edge. `busy` goes to 0 and `done` goes to 1, and `irq` pulses for one cycle if `irq_en` is 1. A `conv_done` pulse outside a conversion changes nothing.
- R9: With `mod_en`=0, `mod_active` is 0 and no acquisition starts. Dropping `mod_en` during acquisition returns to holding without `conv_abort`; dropping it during a conversion aborts it.
- R10: Sleep (`cpu_sleep`=1 with `conv_selfclk`=0) during a conversion gives a one-cycle `conv_abort`, `busy`=0 and `done`=0. After wake, no conversion resumes.
- R11: Idle (`cpu_idle`=1) aborts a conversion when `idle_stop`=1. When `idle_stop`=0, the conversion runs to completion.
- R12: A conversion that completes while `cpu_idle` or `cpu_sleep` is 1, with `irq_en`=0, sets `mod_active` to 0 while `mod_en` stays 1. The block then starts nothing until `mod_en` goes low, even after the low-power state ends.
- R13: Sleep with `conv_selfclk`=1 does not disturb a conversion, and it completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable |
| trig_sel | input | 3 | Source that ends acquisition |
| auto_start | input | 1 | Restart acquisition automatically |
| samp_time | input | SAMP_W | Auto window length in ticks |
| idle_stop | input | 1 | Halt the module in idle |
| cpu_idle | input | 1 | Device is in idle |
| cpu_sleep | input | 1 | Device is in sleep |
| conv_selfclk | input | 1 | Converter runs from its own oscillator |
| irq_en | input | 1 | Completion interrupt enable |
| sw_samp_set | input | 1 | Software acquisition request |
| sw_samp_clr | input | 1 | Software end of acquisition |
| ext_pin | input | 1 | Asynchronous external event pin |
| tmr_match | input | 1 | Timer compare event |
| pwm_evt | input | 1 | PWM interval event |
| tad_tick | input | 1 | One-cycle strobe per converter clock period |
| conv_done | input | 1 | Completion pulse from the converter |
| samp_hold | output | 1 | 1 = acquiring, 0 = holding |
| conv_start | output | 1 | One-cycle convert-start strobe |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Last conversion completed |
| conv_abort | output | 1 | One-cycle strobe when a conversion is dropped |
| irq | output | 1 | One-cycle completion interrupt |
| mod_active | output | 1 | Module is currently operating |

## Verification
The hardest situations to reach are a low-power entry that lands inside a conversion, and the self-shutdown that follows a completion inside idle. Both depend on where the converter's completion falls in time. The bench models the converter with a fixed 12-tick latency after `conv_start`, so it can raise sleep or idle a known few cycles into a conversion. It then injects a stray completion pulse after an abort and holds the device in and out of the low-power state. This shows that nothing restarts until the enable input is toggled.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int TSEL_W = 3;

   // codes of the select field that closes acquisition
   localparam logic [TSEL_W-1:0] TSEL_SW   = 3'b000;
   localparam logic [TSEL_W-1:0] TSEL_PIN  = 3'b001;
   localparam logic [TSEL_W-1:0] TSEL_TMR  = 3'b010;
   localparam logic [TSEL_W-1:0] TSEL_PWM  = 3'b011;
   localparam logic [TSEL_W-1:0] TSEL_AUTO = 3'b111;

   typedef enum logic [1:0] {
      SEQ_HOLD   = 2'd0,
      SEQ_SAMPLE = 2'd1,
      SEQ_CONV   = 2'd2
   } seq_state_e;

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
   parameter int N_IN   = 3,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] async_in,
   output logic [N_IN-1:0] rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("adc_trig_sync: STAGES must be at least 2");
   end
   if (N_IN < 1) begin : g_bad_width
      $error("adc_trig_sync: N_IN must be at least 1");
   end

   for (genvar i = 0; i < N_IN; i++) begin : g_lane
      logic [STAGES:0] shreg;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) shreg <= '0;
         else        shreg <= {shreg[STAGES-1:0], async_in[i]};
      end

      assign rise[i] = shreg[STAGES-1] & ~shreg[STAGES];

      // R4
      single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rise[i] |=> !rise[i]);
   end

endmodule

// File: rtl/adc_samp_timer.sv
module adc_samp_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("adc_samp_timer: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (!run)                   cnt <= '0;
      else if (tick && (cnt < limit))  cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt >= limit);

   // R5
   window_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (cnt == '0));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic auto_start,
   input  logic sw_set,
   input  logic end_samp,
   input  logic conv_done,
   input  logic irq_en,
   output logic samp_hold,
   output logic busy,
   output logic conv_start,
   output logic done,
   output logic conv_abort,
   output logic irq,
   output logic accept
);

   seq_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SEQ_HOLD;
         conv_start <= 1'b0;
         done       <= 1'b0;
         conv_abort <= 1'b0;
         irq        <= 1'b0;
      end else begin
         conv_start <= 1'b0;
         conv_abort <= 1'b0;
         irq        <= 1'b0;
         unique case (state)
            SEQ_HOLD: begin
               if (active && (auto_start || sw_set)) state <= SEQ_SAMPLE;
            end
            SEQ_SAMPLE: begin
               if (!active) begin
                  state <= SEQ_HOLD;
               end else if (end_samp) begin
                  state      <= SEQ_CONV;
                  conv_start <= 1'b1;
                  done       <= 1'b0;
               end
            end
            SEQ_CONV: begin
               if (!active) begin
                  state      <= SEQ_HOLD;
                  conv_abort <= 1'b1;
               end else if (conv_done) begin
                  done  <= 1'b1;
                  irq   <= irq_en;
                  state <= auto_start ? SEQ_SAMPLE : SEQ_HOLD;
               end
            end
            default: state <= SEQ_HOLD;
         endcase
      end
   end

   assign samp_hold = (state == SEQ_SAMPLE);
   assign busy      = (state == SEQ_CONV);
   assign accept    = (state == SEQ_CONV) && active && conv_done;

   // R3
   start_from_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> (busy && !done && $past(samp_hold)));

   // R8
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy && conv_done));

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done && $past(irq_en)));

   // R10
   abort_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_abort |-> (!busy && $past(busy)));

   // R9
   inactive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (state == SEQ_HOLD));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int SAMP_W        = 5,
   parameter int SYNC_STAGES   = 2,
   parameter bit AUTO_TIMER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_en,
   input  logic [TSEL_W-1:0] trig_sel,
   input  logic              auto_start,
   input  logic [SAMP_W-1:0] samp_time,
   input  logic              idle_stop,
   input  logic              cpu_idle,
   input  logic              cpu_sleep,
   input  logic              conv_selfclk,
   input  logic              irq_en,
   input  logic              sw_samp_set,
   input  logic              sw_samp_clr,
   input  logic              ext_pin,
   input  logic              tmr_match,
   input  logic              pwm_evt,
   input  logic              tad_tick,
   input  logic              conv_done,
   output logic              samp_hold,
   output logic              conv_start,
   output logic              busy,
   output logic              done,
   output logic              conv_abort,
   output logic              irq,
   output logic              mod_active
);

   localparam int N_EVT = 3;

   if (SAMP_W < 1 || SAMP_W > 16) begin : g_bad_samp_w
      $error("adc_seq_ctrl: SAMP_W out of range");
   end

   logic [N_EVT-1:0] evt_rise;
   logic             win_expired;
   logic             end_samp;
   logic             halt;
   logic             self_off;
   logic             accept;
   logic             low_pwr;

   adc_trig_sync #(
      .N_IN   (N_EVT),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({pwm_evt, tmr_match, ext_pin}),
      .rise     (evt_rise)
   );

   if (AUTO_TIMER_EN) begin : g_timer
      adc_samp_timer #(
         .CNT_W (SAMP_W)
      ) u_timer (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (samp_hold),
         .tick    (tad_tick),
         .limit   (samp_time),
         .expired (win_expired)
      );
   end else begin : g_no_timer
      assign win_expired = 1'b0;
   end

   always_comb begin
      unique case (trig_sel)
         TSEL_SW:   end_samp = sw_samp_clr;
         TSEL_PIN:  end_samp = evt_rise[0];
         TSEL_TMR:  end_samp = evt_rise[1];
         TSEL_PWM:  end_samp = evt_rise[2];
         TSEL_AUTO: end_samp = win_expired;
         default:   end_samp = 1'b0;
      endcase
   end

   assign halt       = (cpu_idle && idle_stop) || (cpu_sleep && !conv_selfclk);
   assign low_pwr    = cpu_idle || cpu_sleep;
   assign mod_active = mod_en && !self_off && !halt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               self_off <= 1'b0;
      else if (!mod_en)                         self_off <= 1'b0;
      else if (accept && low_pwr && !irq_en)    self_off <= 1'b1;
   end

   adc_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (mod_active),
      .auto_start (auto_start),
      .sw_set     (sw_samp_set),
      .end_samp   (end_samp),
      .conv_done  (conv_done),
      .irq_en     (irq_en),
      .samp_hold  (samp_hold),
      .busy       (busy),
      .conv_start (conv_start),
      .done       (done),
      .conv_abort (conv_abort),
      .irq        (irq),
      .accept     (accept)
   );

   // R12
   self_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_en && $past(mod_en) && $past(self_off)) |-> !mod_active);

   // R2
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({samp_hold, busy}));

endmodule

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mod_en = 1'b0;
   logic [2:0] trig_sel = 3'b000;
   logic       auto_start = 1'b0;
   logic [4:0] samp_time = 5'd0;
   logic       idle_stop = 1'b0;
   logic       cpu_idle = 1'b0;
   logic       cpu_sleep = 1'b0;
   logic       conv_selfclk = 1'b0;
   logic       irq_en = 1'b0;
   logic       sw_samp_set = 1'b0;
   logic       sw_samp_clr = 1'b0;
   logic       ext_pin = 1'b0;
   logic       tmr_match = 1'b0;
   logic       pwm_evt = 1'b0;
   logic       tad_tick = 1'b1;
   logic       mdl_done;
   logic       inj_done = 1'b0;
   logic       conv_done;
   logic       samp_hold, conv_start, busy, done, conv_abort, irq, mod_active;
   logic [4:0] mcnt;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   assign conv_done = mdl_done | inj_done;

   always #10 clk = ~clk;

   adc_seq_ctrl u_adc_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .trig_sel(trig_sel),
      .auto_start(auto_start), .samp_time(samp_time), .idle_stop(idle_stop),
      .cpu_idle(cpu_idle), .cpu_sleep(cpu_sleep), .conv_selfclk(conv_selfclk),
      .irq_en(irq_en), .sw_samp_set(sw_samp_set), .sw_samp_clr(sw_samp_clr),
      .ext_pin(ext_pin), .tmr_match(tmr_match), .pwm_evt(pwm_evt),
      .tad_tick(tad_tick), .conv_done(conv_done), .samp_hold(samp_hold),
      .conv_start(conv_start), .busy(busy), .done(done), .conv_abort(conv_abort),
      .irq(irq), .mod_active(mod_active)
   );

   // converter model: completion 12 ticks after the start strobe
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcnt     <= '0;
         mdl_done <= 1'b0;
      end else begin
         mdl_done <= 1'b0;
         if (conv_abort) mcnt <= '0;
         else if (conv_start) mcnt <= 5'd11;
         else if (mcnt != 0 && tad_tick) begin
            mcnt <= mcnt - 1'b1;
            if (mcnt == 5'd1) mdl_done <= 1'b1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic start_sample();
      sw_samp_set = 1'b1;
      @(negedge clk);
      sw_samp_set = 1'b0;
   endtask

   task automatic sw_end();
      sw_samp_clr = 1'b1;
      @(negedge clk);
      sw_samp_clr = 1'b0;
   endtask

   task automatic wait_hold();
      for (int k = 0; k < 300 && (busy || samp_hold); k++) @(negedge clk);
   endtask

   task automatic set_stim(input int s, input logic v);
      case (s)
         1: sw_samp_clr = v;
         2: ext_pin = v;
         3: tmr_match = v;
         4: pwm_evt = v;
         default: ;
      endcase
   endtask

   function automatic string tag_of(input logic [2:0] s);
      if (s == 3'b000) return "R3";
      if (s == 3'b111) return "R5";
      if (s <= 3'b011) return "R4";
      return "R6";
   endfunction

   // {trig_sel, samp_time, stimulus(1 clr,2 pin,3 tmr,4 pwm), expected acquire cycles, 0 = never}
   localparam logic [16:0] VEC [11] = '{
      {3'b000, 5'd0,  3'd1, 6'd2},
      {3'b001, 5'd0,  3'd2, 6'd4},
      {3'b010, 5'd0,  3'd3, 6'd4},
      {3'b011, 5'd0,  3'd4, 6'd4},
      {3'b111, 5'd0,  3'd0, 6'd1},
      {3'b111, 5'd5,  3'd0, 6'd6},
      {3'b111, 5'd31, 3'd0, 6'd32},
      {3'b111, 5'd3,  3'd2, 6'd4},
      {3'b001, 5'd0,  3'd3, 6'd0},
      {3'b100, 5'd0,  3'd1, 6'd0},
      {3'b110, 5'd0,  3'd2, 6'd0}
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      step(3);
      // R1: outputs during reset
      chk(!samp_hold && !conv_start && !busy && !done && !irq && !conv_abort,
          "R1 reset outputs", {samp_hold, busy, done}, 0);
      rst_n = 1'b1;
      step(2);
      // R9: disabled module is inactive and ignores requests
      chk(mod_active == 1'b0, "R9 inactive when disabled", mod_active, 0);
      start_sample();
      step(1);
      chk(samp_hold == 1'b0, "R9 no start when disabled", samp_hold, 0);
      mod_en = 1'b1;
      step(1);

      // table walk
      for (int i = 0; i < 11; i++) begin
         logic [16:0] v;
         int cnt;
         bit ended;
         bit cs;
         int b;
         string tg;
         v = VEC[i];
         tg = tag_of(v[16:14]);
         trig_sel = v[16:14];
         samp_time = v[13:9];
         step(1);
         start_sample();
         cnt = 0; ended = 0; cs = 0;
         for (int c = 1; c <= 40; c++) begin
            if (!samp_hold) begin
               ended = 1; cs = conv_start;
               break;
            end
            cnt++;
            if (c == 2) set_stim(int'(v[8:6]), 1'b1);
            if (c == 3) set_stim(int'(v[8:6]), 1'b0);
            @(negedge clk);
         end
         set_stim(int'(v[8:6]), 1'b0);
         if (v[5:0] == 6'd0) begin
            chk(!ended, {tg, " acquisition must not end"}, cnt, 40);
            mod_en = 1'b0;
            step(1);
            // R9: leaving acquisition via enable gives no abort
            chk(!samp_hold && !conv_abort, "R9 disable during acquisition",
                {samp_hold, conv_abort}, 0);
            mod_en = 1'b1;
            step(1);
         end else begin
            chk(ended && cnt == int'(v[5:0]), {tg, " acquire length"}, cnt, int'(v[5:0]));
            chk(cs && busy && !done, {tg, " start strobe"}, {cs, busy, done}, 3'b110);
            b = 0;
            while (busy && b < 30) begin
               b++;
               @(negedge clk);
            end
            chk(b == 13 && done, "R8 conversion length", b, 13);
            chk(!samp_hold, "R2 no restart without auto_start", samp_hold, 0);
         end
      end

      // R2 + R8: auto restart and interrupt
      trig_sel = 3'b111; samp_time = 5'd2; irq_en = 1'b1; auto_start = 1'b1;
      step(1);
      begin
         int a;
         a = 0;
         while (samp_hold && a < 40) begin a++; @(negedge clk); end
         chk(a == 3, "R2 auto start window", a, 3);
         a = 0;
         while (busy && a < 40) begin a++; @(negedge clk); end
         chk(done && irq && samp_hold, "R2 auto restart after completion",
             {done, irq, samp_hold}, 3'b111);
         auto_start = 1'b0;
         step(1);
         chk(!irq, "R8 irq single cycle", irq, 0);
      end
      wait_hold();

      // R7: edge while holding is discarded
      trig_sel = 3'b001; irq_en = 1'b0;
      ext_pin = 1'b1; step(2); ext_pin = 1'b0; step(4);
      chk(!busy && !samp_hold, "R7 no action while holding", busy, 0);
      start_sample();
      step(8);
      chk(samp_hold && !busy, "R7 stale edge discarded", samp_hold, 1);
      ext_pin = 1'b1; step(1); ext_pin = 1'b0;
      wait_hold();

      // R10: sleep abort, stray completion, no resume
      trig_sel = 3'b000;
      start_sample(); sw_end(); step(3);
      cpu_sleep = 1'b1;
      step(1);
      chk(conv_abort && !busy && !done, "R10 sleep abort", {conv_abort, busy, done}, 3'b100);
      inj_done = 1'b1; step(1); inj_done = 1'b0; step(1);
      chk(!done && !busy, "R8 stray completion ignored", done, 0);
      cpu_sleep = 1'b0;
      begin
         bit seen;
         seen = 0;
         for (int k = 0; k < 20; k++) begin
            if (busy || conv_start) seen = 1;
            @(negedge clk);
         end
         chk(!seen && !done, "R10 no resume after wake", seen, 0);
      end

      // R13: sleep with own clock keeps converting
      conv_selfclk = 1'b1; irq_en = 1'b1;
      start_sample(); sw_end(); step(2);
      cpu_sleep = 1'b1;
      wait_hold();
      chk(done && mod_active, "R13 conversion survives sleep", {done, mod_active}, 2'b11);
      cpu_sleep = 1'b0; conv_selfclk = 1'b0;
      step(1);

      // R11: idle with stop bit aborts, without it completes
      idle_stop = 1'b1;
      start_sample(); sw_end(); step(2);
      cpu_idle = 1'b1;
      step(1);
      chk(conv_abort && !busy && !done, "R11 idle stop abort", {conv_abort, busy, done}, 3'b100);
      cpu_idle = 1'b0; idle_stop = 1'b0;
      step(1);
      start_sample(); sw_end(); step(2);
      cpu_idle = 1'b1;
      wait_hold();
      chk(done && mod_active, "R11 idle continue completes", {done, mod_active}, 2'b11);
      cpu_idle = 1'b0;
      step(1);

      // R12: self shutdown on completion in idle with interrupt disabled
      irq_en = 1'b0;
      start_sample(); sw_end(); step(2);
      cpu_idle = 1'b1;
      wait_hold();
      chk(done && !mod_active && mod_en, "R12 self shutdown", mod_active, 0);
      auto_start = 1'b1;
      start_sample();
      cpu_idle = 1'b0;
      step(10);
      chk(!samp_hold && !busy && !mod_active, "R12 stays off after wake", mod_active, 0);
      trig_sel = 3'b111; samp_time = 5'd0;
      mod_en = 1'b0; step(1);
      mod_en = 1'b1; step(1);
      chk(mod_active && samp_hold, "R12 enable toggle revives", {mod_active, samp_hold}, 2'b11);
      auto_start = 1'b0;
      wait_hold();

      // R9: enable dropped mid-conversion aborts
      trig_sel = 3'b000;
      start_sample(); sw_end(); step(2);
      mod_en = 1'b0;
      step(1);
      chk(conv_abort && !busy, "R9 disable aborts conversion", conv_abort, 1);
      mod_en = 1'b1;
      step(2);

      // R1: reset after a completed conversion clears done and drops a conversion
      start_sample(); sw_end(); wait_hold();
      chk(done, "R1 precondition done", done, 1);
      start_sample(); sw_end(); step(2);
      rst_n = 1'b0;
      step(1);
      chk(!busy && !done && !samp_hold, "R1 reset mid conversion", {busy, done}, 0);
      rst_n = 1'b1;
      step(20);
      chk(!busy && !done, "R1 nothing resumes after reset", busy, 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule